// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block gathers interrupt events from eight source groups, each of which has a sticky status register and a mask register of its own. It combines them into a global summary word, with one bit per group, and drives a single shared interrupt request pin. A host reads and writes the registers through a simple port. The port has a read strobe, a write strobe, an address and data. Reading a group's status register returns the pending bits and clears them in the same access.

Each group's status bits record raw events and are not affected by its mask. A group's summary bit is set when at least one of its status bits is pending and unmasked. A two-state request machine raises the request when the summary becomes non-zero and drops it when the summary returns to zero. The states are `REQ_QUIET` and `REQ_RAISED`, with the transitions *raise* and *drop*. A pin-mode register decides how the request appears on the pin: push-pull active low, push-pull active high, or open drain. In open drain the pin value is held low and only the output enable moves.

The address map for the default of eight groups is:
- 0x00 to 0x07: status of groups 0 to 7, read-to-clear.
- 0x08 to 0x0F: masks of groups 0 to 7, read/write.
- 0x10: global summary, read-only.
- 0x11: pin mode in bits [1:0].

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every mask register reads 0xFF, every status register and the summary read 0x00, the pin mode reads 0, and the pin is inactive, with `irq_pin_o`=1 and `irq_oe_o`=1.
- R2: An event bit on `evt_i` (group g occupies bits [8g+7:8g]) sets the matching status bit at the next clock edge, whether masked or not.
- R3: A read of status address g returns the pending bits and clears them at that edge. An event bit arriving in the same cycle remains set.
- R4: Mask register g (address 0x08+g) reads back what was written. A mask bit of 1 stops its status bit from reaching the summary.
- R5: Summary bit g at address 0x10 is 1 when group g holds a status bit whose mask bit is 0. Reading the summary clears nothing.
- R6: The request moves from `REQ_QUIET` to `REQ_RAISED` one clock edge after the summary becomes non-zero. It moves back one edge after the summary becomes zero.
- R7: Pin mode 0 (push-pull, active low) drives `irq_pin_o` to the inverse of the request and holds `irq_oe_o`=1.
- R8: Pin mode 1 (push-pull, active high) drives `irq_pin_o` to the request and holds `irq_oe_o`=1.
- R9: Pin modes 2 and 3 (open drain) hold `irq_pin_o`=0 and drive `irq_oe_o` to the request.
- R10: Writes to status or summary addresses have no effect. The pin mode reads back in bits [1:0], with the upper bits 0.
- R11: A read of an unmapped address (0x12 to 0x1F) returns 0, and `rdata_o` is 0 whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 64 | Event pulses, eight bits per group |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears status on read) |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the address |
| irq_pin_o | output | 1 | Interrupt pin value |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The assertions are checked on every cycle and cover the following behaviour:
- Event capture into status.
- The clearing of a group that was read with no new event.
- The one-edge lag of the request state behind the summary.
- The pin constraints of each mode.
- The reset values of the masks.

Only the bench scenarios can show the read-back values, the masking of pending bits, and the priority of an event over a read-clear in the same cycle. They are also the only way to show that writes to read-only addresses are ignored and that the summary survives a read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        PIN_PP_LOW  = 2'b00,
        PIN_PP_HIGH = 2'b01,
        PIN_OD      = 2'b10,
        PIN_OD_ALT  = 2'b11
    } pin_mode_e;

    typedef enum logic {
        REQ_QUIET  = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_e;

endpackage

// File: rtl/irq_group_regs.sv
module irq_group_regs #(
    parameter int NGRP  = 8,
    parameter int GRP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NGRP*GRP_W-1:0] evt_i,
    input  logic [NGRP-1:0]       clr_i,
    input  logic [NGRP-1:0]       mask_we_i,
    input  logic [GRP_W-1:0]      wdata_i,
    output logic [NGRP*GRP_W-1:0] status_o,
    output logic [NGRP*GRP_W-1:0] mask_o
);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GRP_W-1:0] stat_q;
        logic [GRP_W-1:0] mask_q;
        logic [GRP_W-1:0] evt_slice;

        assign evt_slice = evt_i[g*GRP_W +: GRP_W];

        // A read-clear keeps only the bits of new events.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q <= '0;
            end else if (clr_i[g]) begin
                stat_q <= evt_slice;
            end else begin
                stat_q <= stat_q | evt_slice;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q <= '1;
            end else if (mask_we_i[g]) begin
                mask_q <= wdata_i;
            end
        end

        assign status_o[g*GRP_W +: GRP_W] = stat_q;
        assign mask_o[g*GRP_W +: GRP_W]   = mask_q;
    end

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int NGRP  = 8,
    parameter int GRP_W = 8
) (
    input  logic [NGRP*GRP_W-1:0] status_i,
    input  logic [NGRP*GRP_W-1:0] mask_i,
    output logic [NGRP-1:0]       glob_o,
    output logic                  any_o
);

    for (genvar g = 0; g < NGRP; g++) begin : g_sum
        assign glob_o[g] = |(status_i[g*GRP_W +: GRP_W] & ~mask_i[g*GRP_W +: GRP_W]);
    end

    assign any_o = |glob_o;

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_agg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      any_i,
    input  pin_mode_e mode_i,
    output logic      req_o,
    output logic      pin_o,
    output logic      oe_o
);

    req_state_e state_q;
    req_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: raise (quiet -> raised), drop (raised -> quiet)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_QUIET:  if (any_i)  state_d = REQ_RAISED;
            REQ_RAISED: if (!any_i) state_d = REQ_QUIET;
        endcase
    end

    always_comb begin
        req_o = (state_q == REQ_RAISED);
        pin_o = 1'b1;
        oe_o  = 1'b1;
        unique case (mode_i)
            PIN_PP_LOW: begin
                pin_o = ~req_o;
                oe_o  = 1'b1;
            end
            PIN_PP_HIGH: begin
                pin_o = req_o;
                oe_o  = 1'b1;
            end
            PIN_OD, PIN_OD_ALT: begin
                pin_o = 1'b0;
                oe_o  = req_o;
            end
        endcase
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NGRP  = 8,
    parameter int GRP_W = 8,
    localparam int ADDR_W = $clog2(2*NGRP + 2),
    localparam int EVT_W  = NGRP*GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [GRP_W-1:0]  wdata_i,
    output logic [GRP_W-1:0]  rdata_o,
    output logic              irq_pin_o,
    output logic              irq_oe_o
);

    localparam int MASK_BASE = NGRP;
    localparam logic [ADDR_W-1:0] GLOB_ADDR = ADDR_W'(2*NGRP);
    localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(2*NGRP + 1);

    logic [EVT_W-1:0] status_flat;
    logic [EVT_W-1:0] mask_flat;
    logic [NGRP-1:0]  glob;
    logic             any_pend;
    logic             req_active;
    logic [NGRP-1:0]  clr_hit;
    logic [NGRP-1:0]  mask_we;
    pin_mode_e        pin_mode;

    for (genvar g = 0; g < NGRP; g++) begin : g_dec
        assign clr_hit[g] = rd_en_i && (addr_i == ADDR_W'(g));
        assign mask_we[g] = wr_en_i && (addr_i == ADDR_W'(MASK_BASE + g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_mode <= PIN_PP_LOW;
        end else if (wr_en_i && addr_i == CFG_ADDR) begin
            pin_mode <= pin_mode_e'(wdata_i[1:0]);
        end
    end

    irq_group_regs #(.NGRP(NGRP), .GRP_W(GRP_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (clr_hit),
        .mask_we_i(mask_we),
        .wdata_i  (wdata_i),
        .status_o (status_flat),
        .mask_o   (mask_flat)
    );

    irq_summary #(.NGRP(NGRP), .GRP_W(GRP_W)) u_sum (
        .status_i(status_flat),
        .mask_i  (mask_flat),
        .glob_o  (glob),
        .any_o   (any_pend)
    );

    irq_pin_ctrl u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .any_i (any_pend),
        .mode_i(pin_mode),
        .req_o (req_active),
        .pin_o (irq_pin_o),
        .oe_o  (irq_oe_o)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            for (int g = 0; g < NGRP; g++) begin
                if (addr_i == ADDR_W'(g))
                    rdata_o = status_flat[g*GRP_W +: GRP_W];
                if (addr_i == ADDR_W'(MASK_BASE + g))
                    rdata_o = mask_flat[g*GRP_W +: GRP_W];
            end
            if (addr_i == GLOB_ADDR)
                rdata_o = GRP_W'(glob);
            if (addr_i == CFG_ADDR)
                rdata_o = GRP_W'(pin_mode);
        end
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int NGRP  = 8,
    parameter int GRP_W = 8,
    localparam int ADDR_W = $clog2(2*NGRP + 2),
    localparam int EVT_W  = NGRP*GRP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [EVT_W-1:0]  evt_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [EVT_W-1:0]  status_flat,
    input logic [EVT_W-1:0]  mask_flat,
    input logic [NGRP-1:0]   glob,
    input logic              req_active,
    input pin_mode_e         pin_mode,
    input logic              irq_pin_o,
    input logic              irq_oe_o
);

    // R1
    reset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((&mask_flat) && (status_flat == '0)));

    // R2
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_flat & $past(evt_i)) == $past(evt_i)));

    for (genvar g = 0; g < NGRP; g++) begin : g_clr
        // R3
        rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en_i && addr_i == ADDR_W'(g) && evt_i[g*GRP_W +: GRP_W] == '0)
            |=> (status_flat[g*GRP_W +: GRP_W] == '0));
    end

    // R6
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_active == ($past(glob) != '0)));

    // R7
    pp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode == PIN_PP_LOW || pin_mode == PIN_PP_HIGH) |-> irq_oe_o);

    // R9
    od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode == PIN_OD || pin_mode == PIN_OD_ALT) |-> (irq_pin_o == 1'b0));

endmodule

bind irq_aggregator irq_aggregator_chk #(.NGRP(NGRP), .GRP_W(GRP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .status_flat(status_flat),
    .mask_flat  (mask_flat),
    .glob       (glob),
    .req_active (req_active),
    .pin_mode   (pin_mode),
    .irq_pin_o  (irq_pin_o),
    .irq_oe_o   (irq_oe_o)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        irq_pin_o;
    logic        irq_oe_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    irq_aggregator u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .irq_pin_o(irq_pin_o),
        .irq_oe_o (irq_oe_o)
    );

    // Monitor: compare each read against the scoreboard
    always @(negedge clk) begin
        if (rd_en_i) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rdata_o !== e) begin
                n_fail++;
                $display("FAIL %s addr=%0h actual=%02h expected=%02h", t, addr_i, rdata_o, e);
            end
        end
    end

    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en_i = 1'b1;
        addr_i  = a;
        @(posedge clk); #1;
        rd_en_i = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic pulse(input logic [63:0] v);
        @(posedge clk); #1;
        evt_i = v;
        @(posedge clk); #1;
        evt_i = '0;
    endtask

    task automatic check_pin(input logic ep, input logic eo, input string t);
        @(negedge clk);
        n_checks++;
        if (irq_pin_o !== ep || irq_oe_o !== eo) begin
            n_fail++;
            $display("FAIL %s pin/oe actual=%b%b expected=%b%b", t, irq_pin_o, irq_oe_o, ep, eo);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_pin(1'b1, 1'b1, "R1 pin idle");
        rd(5'h08, 8'hFF, "R1 mask0 reset");
        rd(5'h0F, 8'hFF, "R1 mask7 reset");
        rd(5'h03, 8'h00, "R1 status3 reset");
        rd(5'h10, 8'h00, "R1 summary reset");
        rd(5'h11, 8'h00, "R1 mode reset");

        // R2 capture while masked, R3 clear on read
        pulse(64'h05 << 16);
        rd(5'h02, 8'h05, "R2 masked capture");
        rd(5'h02, 8'h00, "R3 cleared by read");
        check_pin(1'b1, 1'b1, "R4 masked no request");

        // R4 mask read-back and suppression
        wr(5'h0A, 8'hFE);
        rd(5'h0A, 8'hFE, "R4 mask2 readback");
        pulse(64'h06 << 16);
        rd(5'h10, 8'h00, "R4 masked bits hidden");
        pulse(64'h01 << 16);
        check_pin(1'b1, 1'b1, "R6 one edge lag");
        check_pin(1'b0, 1'b1, "R7 active low asserted");
        rd(5'h10, 8'h04, "R5 summary group2");
        rd(5'h10, 8'h04, "R5 summary not cleared");

        // R8 / R9 pin modes
        wr(5'h11, 8'h01);
        check_pin(1'b1, 1'b1, "R8 active high asserted");
        wr(5'h11, 8'h02);
        check_pin(1'b0, 1'b1, "R9 open drain asserted");
        wr(5'h11, 8'hFF);
        rd(5'h11, 8'h03, "R10 mode readback");
        check_pin(1'b0, 1'b1, "R9 alt open drain asserted");

        // R3 clear, R6 drop lag
        rd(5'h02, 8'h07, "R3 status2 pending");
        check_pin(1'b0, 1'b1, "R6 drop lag");
        check_pin(1'b0, 1'b0, "R9 released");

        // R3 event wins over same-cycle clear
        wr(5'h0D, 8'h00);
        pulse(64'h30 << 40);
        @(posedge clk); #1;
        exp_q.push_back(8'h30);
        tag_q.push_back("R3 read with collision");
        rd_en_i = 1'b1;
        addr_i  = 5'h05;
        evt_i   = 64'h01 << 40;
        @(posedge clk); #1;
        rd_en_i = 1'b0;
        evt_i   = '0;
        rd(5'h05, 8'h01, "R3 event kept over clear");

        // R10 writes to read-only addresses ignored
        wr(5'h05, 8'hFF);
        rd(5'h05, 8'h00, "R10 status write ignored");
        wr(5'h10, 8'hFF);
        rd(5'h10, 8'h00, "R10 summary write ignored");

        // R11 unmapped and idle read data
        rd(5'h1F, 8'h00, "R11 unmapped read");
        @(negedge clk);
        n_checks++;
        if (rdata_o !== 8'h00) begin
            n_fail++;
            $display("FAIL R11 idle rdata actual=%02h expected=00", rdata_o);
        end

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard residue actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule